// File: doc/BRIEF.md
# Modem Line Control and Status Register Pair

This block holds the modem control and modem status registers of a 16550-style serial port. The control register drives four handshake outputs (request-to-send, terminal-ready and two general-purpose outputs). It also carries a loopback switch. The status register samples four handshake inputs through a synchronizer: clear-to-send, set-ready, carrier-detect and ring. It keeps sticky change flags for these lines and raises an interrupt request while any change flag is set.

Software reaches both registers through a byte-wide port with one select bit. A status read returns the line levels and change flags as they stood before the read, then clears the flags. When loopback is on, the status logic compares against the control outputs instead of the external pins, with outputs and inputs crossed. The external request-to-send and terminal-ready pins are held low during loopback.

Top module: `modem_line_ctrl`

## Requirements
- R1: After a synchronous reset the control register reads 8'h08 (only OUT2 set). The status register reads 8'hB0 (carrier, set-ready and clear-to-send high, ring low, no change flags). The OUT2 pin is 1, the other three output pins are 0, and the interrupt request is 0.
- R2: `reg_sel`=0 selects the control register and `reg_sel`=1 selects the status register. A control write keeps write-data bits 4:0 (bit4 loopback, bit3 OUT2, bit2 OUT1, bit1 RTS, bit0 DTR). Bits 7:5 read back as zero.
- R3: Outside loopback, the output pins follow the control bits listed in R2 from the clock edge that performs the write.
- R4: While control bit4 is set, the RTS and DTR pins are 0 and the OUT1 and OUT2 pins still follow their control bits.
- R5: Status layout: bit7 carrier, bit6 ring, bit5 set-ready, bit4 clear-to-send, bit3 carrier changed, bit2 ring fell, bit1 set-ready changed, bit0 clear-to-send changed. Bits 3, 1 and 0 are set when their line toggles, in either direction.
- R6: Status bit2 is set only when the ring line goes from 1 to 0, never on a rise.
- R7: A status read returns the register as it stood before the read and clears bits 3:0. A change arriving on the same edge as the read is kept as a set flag. Without a read, change flags stay set.
- R8: In loopback, the compared lines are OUT2 as carrier, OUT1 as ring, RTS as clear-to-send and DTR as set-ready. They are visible in bits 7:4 one edge after the control write.
- R9: `msi_req_o` is 1 exactly when any of status bits 3:0 is set.
- R10: Writes with `reg_sel`=1 have no effect on the status register, the pins or the interrupt request.
- R11: A change on an external input pin reaches the status register on the third rising edge after it is applied: two synchronizer flops, then the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered on a read strobe |
| pin_cts_i | input | 1 | External clear-to-send |
| pin_dsr_i | input | 1 | External set-ready |
| pin_dcd_i | input | 1 | External carrier-detect |
| pin_ri_i | input | 1 | External ring |
| pin_rts_o | output | 1 | Request-to-send output |
| pin_dtr_o | output | 1 | Terminal-ready output |
| pin_out1_o | output | 1 | General output 1 |
| pin_out2_o | output | 1 | General output 2 |
| msi_req_o | output | 1 | Modem status interrupt request |

## Verification
The clear-on-read of the change flags and the arrival of a new line change can fall on the same clock edge. The bench provokes this by arranging a pin change that reaches the register exactly on the read edge, with a different flag already pending. It then judges that the read data shows only the old flag and that a following read shows the new flag alone. The same collision also arises when a loopback control write changes the compared lines, and the loopback sweep covers it with an extra flag-clearing read.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  // control register bit positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;
  localparam int MC_W    = 5;

  // line nibble positions (status bits 7:4 and 3:0 share this order)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  localparam int LN_W   = 4;

  localparam logic [MC_W-1:0] MC_RESET         = 5'b01000;
  localparam logic [LN_W-1:0] LN_RESET         = 4'b1011;
  localparam logic [LN_W-1:0] LEVEL_DELTA_MASK = 4'b1011;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [MC_W-1:0]   ctrl_q,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              out1_o,
  output logic              out2_o
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:MC_W];

  // pins are registered next to the control bits so they switch together
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= MC_RESET;
      rts_o  <= 1'b0;
      dtr_o  <= 1'b0;
      out1_o <= MC_RESET[MC_OUT1];
      out2_o <= MC_RESET[MC_OUT2];
    end else if (wr_en) begin
      ctrl_q <= wdata[MC_W-1:0];
      rts_o  <= wdata[MC_RTS] & ~wdata[MC_LOOP];
      dtr_o  <= wdata[MC_DTR] & ~wdata[MC_LOOP];
      out1_o <= wdata[MC_OUT1];
      out2_o <= wdata[MC_OUT2];
    end
  end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_line_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [LN_W-1:0] ext_lines,
  input  logic [LN_W-1:0] loop_lines,
  input  logic            loop_en,
  input  logic            rd_clr,
  output logic [LN_W-1:0] line_q,
  output logic [LN_W-1:0] delta_q
);
  logic [LN_W-1:0] src, chg, fresh, delta_d;

  always_comb begin
    src   = loop_en ? loop_lines : ext_lines;
    chg   = src ^ line_q;
    fresh = chg & LEVEL_DELTA_MASK;
    fresh[LN_RI] = line_q[LN_RI] & ~src[LN_RI];
    // a read clears old flags, but a change on the same edge survives
    delta_d = (rd_clr ? '0 : delta_q) | fresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= LN_RESET;
      delta_q <= '0;
    end else begin
      line_q  <= src;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_cts_i,
  input  logic              pin_dsr_i,
  input  logic              pin_dcd_i,
  input  logic              pin_ri_i,
  output logic              pin_rts_o,
  output logic              pin_dtr_o,
  output logic              pin_out1_o,
  output logic              pin_out2_o,
  output logic              msi_req_o
);
  localparam int STAT_W = 2 * LN_W;

  logic [MC_W-1:0] ctrl_q;
  logic [LN_W-1:0] line_q, delta_q;
  logic [LN_W-1:0] ext_raw, ext_sync, loop_lines;
  logic            wr_ctrl, rd_stat;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign rd_stat = reg_rd && (reg_sel == SEL_STAT);

  always_comb begin
    ext_raw = '0;
    ext_raw[LN_DCD] = pin_dcd_i;
    ext_raw[LN_RI]  = pin_ri_i;
    ext_raw[LN_DSR] = pin_dsr_i;
    ext_raw[LN_CTS] = pin_cts_i;
    // crossed loopback routing
    loop_lines = '0;
    loop_lines[LN_DCD] = ctrl_q[MC_OUT2];
    loop_lines[LN_RI]  = ctrl_q[MC_OUT1];
    loop_lines[LN_DSR] = ctrl_q[MC_DTR];
    loop_lines[LN_CTS] = ctrl_q[MC_RTS];
  end

  modem_line_sync #(
    .W(LN_W), .STAGES(SYNC_STAGES), .RST_VAL(LN_RESET)
  ) sync_i (
    .clk(clk), .rst(rst), .d(ext_raw), .q(ext_sync)
  );

  modem_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .rts_o(pin_rts_o), .dtr_o(pin_dtr_o),
    .out1_o(pin_out1_o), .out2_o(pin_out2_o)
  );

  modem_status_reg stat_i (
    .clk(clk), .rst(rst), .ext_lines(ext_sync), .loop_lines(loop_lines),
    .loop_en(ctrl_q[MC_LOOP]), .rd_clr(rd_stat),
    .line_q(line_q), .delta_q(delta_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_sel == SEL_STAT) reg_rdata <= DATA_W'({line_q, delta_q});
      else                     reg_rdata <= DATA_W'(ctrl_q);
    end
  end

  assign msi_req_o = |delta_q;

  logic unused_stat_w;
  assign unused_stat_w = (STAT_W == 0);
endmodule

// File: rtl/modem_line_ctrl_chk.sv
module modem_line_ctrl_chk
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pin_rts_o,
  input logic              pin_dtr_o,
  input logic [MC_W-1:0]   ctrl_q,
  input logic [LN_W-1:0]   line_q,
  input logic [LN_W-1:0]   delta_q
);
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel) |=> ctrl_q == $past(reg_wdata[MC_W-1:0]));

  assert_loop_pins_low_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[MC_LOOP] |-> (!pin_rts_o && !pin_dtr_o));

  assert_read_snapshot_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel) |=> reg_rdata == DATA_W'({$past(line_q), $past(delta_q)}));

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_sel) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  assert_ring_fall_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(delta_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI]));

  assert_loop_map_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[MC_LOOP] |=> line_q == {$past(ctrl_q[MC_OUT2]), $past(ctrl_q[MC_OUT1]),
                                   $past(ctrl_q[MC_DTR]), $past(ctrl_q[MC_RTS])});
endmodule

bind modem_line_ctrl modem_line_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_rts_o(pin_rts_o),
  .pin_dtr_o(pin_dtr_o), .ctrl_q(ctrl_q), .line_q(line_q), .delta_q(delta_q)
);

// File: tb/modem_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module modem_line_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pin_cts_i = 1'b1, pin_dsr_i = 1'b1, pin_dcd_i = 1'b1, pin_ri_i = 1'b0;
  logic       pin_rts_o, pin_dtr_o, pin_out1_o, pin_out2_o, msi_req_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_line_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_cts_i(pin_cts_i), .pin_dsr_i(pin_dsr_i), .pin_dcd_i(pin_dcd_i),
    .pin_ri_i(pin_ri_i), .pin_rts_o(pin_rts_o), .pin_dtr_o(pin_dtr_o),
    .pin_out1_o(pin_out1_o), .pin_out2_o(pin_out2_o), .msi_req_o(msi_req_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // nibble order: bit3 carrier, bit2 ring, bit1 set-ready, bit0 clear-to-send
  task automatic set_pins(logic [3:0] v);
    pin_dcd_i = v[3]; pin_ri_i = v[2]; pin_dsr_i = v[1]; pin_cts_i = v[0];
  endtask

  task automatic do_read(logic sel, output logic [7:0] v);
    reg_sel = sel; reg_rd = 1'b1;
    step(1);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic do_write(logic sel, logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  function automatic logic [3:0] exp_delta(logic [3:0] o, logic [3:0] n);
    logic [3:0] d;
    d = (o ^ n) & 4'b1011;
    d[2] = o[2] & ~n[2];
    return d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    check("R1 msi", {7'd0, msi_req_o}, 8'h00);
    check("R1 pins", {4'd0, pin_out2_o, pin_out1_o, pin_rts_o, pin_dtr_o}, 8'h08);
    do_read(1'b0, v); check("R1 ctrl", v, 8'h08);
    do_read(1'b1, v); check("R1 status", v, 8'hB0);

    // R5 R6 R9 R11: all old/new pin pairs
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        logic [3:0] d;
        set_pins(o[3:0]);
        step(4);
        do_read(1'b1, v);
        d = exp_delta(o[3:0], n[3:0]);
        set_pins(n[3:0]);
        step(2);
        check("R11 not yet", {7'd0, msi_req_o}, 8'h00);
        step(1);
        check("R9 msi", {7'd0, msi_req_o}, {7'd0, |d});
        do_read(1'b1, v);
        check(d[2] ? "R6 ring fall" : "R5 status", v, {n[3:0], d});
        do_read(1'b1, v);
        check("R7 cleared", v, {n[3:0], 4'h0});
      end
    end

    // R7 collision: read lands on the edge a new change arrives
    set_pins(4'b1011); step(4); do_read(1'b1, v);
    set_pins(4'b0011); step(4);
    set_pins(4'b0010); step(2);
    do_read(1'b1, v);
    check("R7 collision old", v, 8'h38);
    check("R7 collision msi", {7'd0, msi_req_o}, 8'h01);
    do_read(1'b1, v);
    check("R7 collision new", v, 8'h21);

    // R10 status write ignored
    step(2);
    do_write(1'b1, 8'hFF);
    step(1);
    check("R10 msi", {7'd0, msi_req_o}, 8'h00);
    check("R10 pins", {4'd0, pin_out2_o, pin_out1_o, pin_rts_o, pin_dtr_o}, 8'h08);
    do_read(1'b1, v);
    check("R10 status", v, 8'h20);

    // R2 R3 R4 R8: all control values, junk in upper write bits
    set_pins(4'b1011); step(4); do_read(1'b1, v);
    for (int m = 0; m < 32; m++) begin
      logic [4:0] mb;
      mb = m[4:0];
      do_write(1'b0, {3'b101, mb});
      check(mb[4] ? "R4 pins" : "R3 pins",
            {4'd0, pin_out2_o, pin_out1_o, pin_rts_o, pin_dtr_o},
            {4'd0, mb[3], mb[2], mb[1] & ~mb[4], mb[0] & ~mb[4]});
      do_read(1'b0, v);
      check("R2 ctrl", v, {3'b000, mb});
      if (mb[4]) begin
        do_read(1'b1, v);
        check("R8 loop lines", {4'd0, v[7:4]}, {4'd0, mb[3], mb[2], mb[0], mb[1]});
        do_read(1'b1, v);
        check("R8 flags cleared", {4'd0, v[3:0]}, 8'h00);
      end
    end
    do_write(1'b0, 8'h08);
    step(4);
    do_read(1'b1, v);
    do_read(1'b1, v);
    check("R5 back to pins", v, 8'hB0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule